// File: doc/BRIEF.md
# PAM4 Transmitter Test Pattern Source

This block feeds a PAM4 transmitter lane with test symbols when the link runs with one bit of payload per bit on the wire. Each output beat carries eight unit intervals (UIs). Each UI is a 2-bit symbol whose value is the voltage level, from 0 to 3. A 3-bit mode input selects one of five sources:
- the high-swing toggle,
- the low-swing toggle,
- a 52-UI jitter measurement sequence,
- a compliance sequence of 137 blocks,
- a modified compliance sequence of 65792 blocks.

In the two block-sequenced modes the block emits zero symbols. It publishes the block number, the beat within the block and a marker for the final beat of the sequence, so that a later stage can overlay the content of each block.

Output starts with a one-cycle start strobe. From then on the source is a free-running valid/ready stream. A new mode is taken from the mode input only when the current pattern period has completed, so a period is never cut short. Every phase counter then begins again at zero.

Top module: `pam4_txpat_gen`

## Requirements
- R1: After reset, valid_o and data_o are 0, and they stay 0 until start_i is seen high. valid_o rises on the clock edge that samples start_i and then stays high.
- R2: Mode codes 0, 5, 6 and 7 select the high-swing toggle. Successive UIs alternate between levels 0 (00b) and 3 (11b), and the earliest UI of each beat is level 0. The earliest UI sits in data_o[1:0].
- R3: Mode code 1 selects the low-swing toggle. Successive UIs alternate between levels 1 (01b) and 2 (10b), and the earliest UI of each beat is level 1.
- R4: Mode code 2 selects the jitter sequence. It has 52 UIs in four groups of 13. Each group holds a first level for 7 UIs and then its complement (3 minus the level) for 6 UIs. The first levels are 0, 3, 1, 2, in that order. The UI phase carries across beats, so the period boundary falls every 13 beats.
- R5: In mode codes 3 and 4, data_o is all zero. A block is 128 UIs (16 beats). blk_beat_o counts 0 to 15 within a block, and blk_idx_o increments by one when a block completes.
- R6: In mode code 3, blk_idx_o runs from 0 to 136 and then returns to 0. blk_last_o is high only on beat 15 of block 136.
- R7: In mode code 4, blk_idx_o runs from 0 to 65791 and then returns to 0. blk_last_o is high only on beat 15 of block 65791.
- R8: mode_i is sampled only at start and on the transfer of a period's final beat. The toggle period is 1 beat, the jitter period is 13 beats, and the compliance periods are 2192 and 1052672 beats. Values of mode_i at any other time are ignored. After a switch, all phase and block counters restart at zero.
- R9: While valid_o is high and ready_i is low, data_o, blk_idx_o, blk_beat_o and blk_last_o hold, and no counter advances.
- R10: A start_i pulse while the stream is running has no effect on the output sequence.
- R11: In the toggle and jitter modes, blk_idx_o, blk_beat_o and blk_last_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Requested pattern code (0/5-7 high toggle, 1 low toggle, 2 jitter, 3 compliance, 4 modified compliance) |
| start_i | input | 1 | Begin emitting; ignored once running |
| ready_i | input | 1 | Downstream accepts the current beat |
| valid_o | output | 1 | Beat on data_o is valid |
| data_o | output | 16 | Eight 2-bit symbols, earliest UI in bits [1:0] |
| blk_idx_o | output | 17 | Block number inside a compliance sequence |
| blk_beat_o | output | 4 | Beat number inside the current block |
| blk_last_o | output | 1 | Final beat of the final block of a compliance sequence |

## Verification
The bench keeps mode_i at an unrelated code during every beat except each period's final one. A design that sampled the mode on any transfer would then break the jitter or compliance sequence partway through and restart in the wrong pattern. The stream runs under an irregular ready pattern. A design that advanced a counter while stalled would shift the jitter phase or repeat a block number, and the scoreboard would see misaligned beats. One full 137-block sequence is driven to its wrap. A design with an off-by-one limit would place blk_last_o on the wrong block or skip the switch into the following mode. An aliased mode code and a start pulse in mid-stream are included to catch decode holes and restarts the design should not make.

// File: rtl/pam4_pat_pkg.sv
package pam4_pat_pkg;

  typedef enum logic [2:0] {
    PM_HI_TOG = 3'd0,
    PM_LO_TOG = 3'd1,
    PM_JIT    = 3'd2,
    PM_CPAT   = 3'd3,
    PM_MCPAT  = 3'd4
  } pat_mode_e;

  // Unused codes fall back to the high-swing toggle.
  function automatic pat_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    return PM_LO_TOG;
      3'd2:    return PM_JIT;
      3'd3:    return PM_CPAT;
      3'd4:    return PM_MCPAT;
      default: return PM_HI_TOG;
    endcase
  endfunction

  // Opening level of each 13-UI jitter group; the closing level is its complement.
  function automatic logic [1:0] jit_open_level(input logic [1:0] grp);
    case (grp)
      2'd0:    return 2'd0;
      2'd1:    return 2'd3;
      2'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/pam4_period_ctr.sv
module pam4_period_ctr
  import pam4_pat_pkg::*;
#(
  parameter int UPB        = 8,
  parameter int BPB        = 16,
  parameter int CP_BLOCKS  = 137,
  parameter int MCP_BLOCKS = 65792,
  parameter int JIT_UI     = 52,
  parameter int IDX_W      = 17,
  parameter int BEAT_W     = 4,
  parameter int PH_W       = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              adv,
  input  pat_mode_e         mode,
  output logic [IDX_W-1:0]  blk_q,
  output logic [IDX_W-1:0]  nxt_blk,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] nxt_beat,
  output logic [PH_W-1:0]   nxt_jph,
  output logic              period_end
);

  localparam logic [IDX_W-1:0]  CP_LAST   = IDX_W'(CP_BLOCKS - 1);
  localparam logic [IDX_W-1:0]  MCP_LAST  = IDX_W'(MCP_BLOCKS - 1);
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BPB - 1);
  localparam logic [PH_W:0]     JIT_UI_W  = (PH_W+1)'(JIT_UI);
  localparam logic [PH_W:0]     UPB_W     = (PH_W+1)'(UPB);

  logic [PH_W-1:0] jph_q;
  logic [PH_W:0]   jsum;
  logic [PH_W-1:0] jph_step;
  logic            blk_done;

  always_comb begin
    jsum     = {1'b0, jph_q} + UPB_W;
    jph_step = (jsum >= JIT_UI_W) ? PH_W'(jsum - JIT_UI_W) : PH_W'(jsum);
    blk_done = (beat_q == BEAT_LAST);
  end

  always_comb begin
    case (mode)
      PM_JIT:   period_end = (jph_step == '0);
      PM_CPAT:  period_end = blk_done && (blk_q == CP_LAST);
      PM_MCPAT: period_end = blk_done && (blk_q == MCP_LAST);
      default:  period_end = 1'b1;
    endcase
  end

  always_comb begin
    nxt_blk  = blk_q;
    nxt_beat = beat_q;
    nxt_jph  = jph_q;
    if (restart) begin
      nxt_blk  = '0;
      nxt_beat = '0;
      nxt_jph  = '0;
    end else if (adv) begin
      case (mode)
        PM_JIT: nxt_jph = jph_step;
        PM_CPAT, PM_MCPAT: begin
          nxt_beat = blk_done ? '0 : beat_q + BEAT_W'(1);
          nxt_blk  = blk_done ? blk_q + IDX_W'(1) : blk_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q  <= '0;
      beat_q <= '0;
      jph_q  <= '0;
    end else if (restart || adv) begin
      blk_q  <= nxt_blk;
      beat_q <= nxt_beat;
      jph_q  <= nxt_jph;
    end
  end

endmodule

// File: rtl/pam4_beat_builder.sv
module pam4_beat_builder
  import pam4_pat_pkg::*;
#(
  parameter int UPB         = 8,
  parameter int JIT_UI      = 52,
  parameter int JIT_SET_UI  = 13,
  parameter int JIT_HOLD_UI = 7,
  parameter int PH_W        = 6
) (
  input  pat_mode_e        mode,
  input  logic [PH_W-1:0]  jph,
  output logic [2*UPB-1:0] beat
);

  localparam logic [PH_W:0] JIT_UI_W = (PH_W+1)'(JIT_UI);
  localparam logic [PH_W:0] SET_W    = (PH_W+1)'(JIT_SET_UI);
  localparam logic [PH_W:0] HOLD_W   = (PH_W+1)'(JIT_HOLD_UI);

  for (genvar k = 0; k < UPB; k++) begin : g_ui
    logic [PH_W:0] pos_raw;
    logic [PH_W:0] pos;
    logic [PH_W:0] off;
    logic [1:0]    grp;
    logic [1:0]    open_lvl;
    logic [1:0]    sym;

    always_comb begin
      pos_raw  = {1'b0, jph} + (PH_W+1)'(k);
      pos      = (pos_raw >= JIT_UI_W) ? pos_raw - JIT_UI_W : pos_raw;
      grp      = 2'(pos / SET_W);
      off      = pos % SET_W;
      open_lvl = jit_open_level(grp);
      case (mode)
        PM_HI_TOG: sym = (k % 2 == 1) ? 2'b11 : 2'b00;
        PM_LO_TOG: sym = (k % 2 == 1) ? 2'b10 : 2'b01;
        PM_JIT:    sym = (off < HOLD_W) ? open_lvl : ~open_lvl;
        default:   sym = 2'b00;
      endcase
    end

    assign beat[2*k +: 2] = sym;
  end

endmodule

// File: rtl/pam4_txpat_gen.sv
module pam4_txpat_gen
  import pam4_pat_pkg::*;
#(
  parameter int UI_PER_BEAT = 8,
  parameter int BLOCK_UI    = 128,
  parameter int CP_BLOCKS   = 137,
  parameter int MCP_BLOCKS  = 65792,
  parameter int JIT_SET_UI  = 13,
  parameter int JIT_HOLD_UI = 7,
  localparam int JIT_UI     = 4 * JIT_SET_UI,
  localparam int BPB        = BLOCK_UI / UI_PER_BEAT,
  localparam int IDX_W      = $clog2(MCP_BLOCKS > CP_BLOCKS ? MCP_BLOCKS : CP_BLOCKS),
  localparam int BEAT_W     = $clog2(BPB),
  localparam int PH_W       = $clog2(JIT_UI)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               mode_i,
  input  logic                     start_i,
  input  logic                     ready_i,
  output logic                     valid_o,
  output logic [2*UI_PER_BEAT-1:0] data_o,
  output logic [IDX_W-1:0]         blk_idx_o,
  output logic [BEAT_W-1:0]        blk_beat_o,
  output logic                     blk_last_o
);

  localparam logic [IDX_W-1:0]  CP_LAST   = IDX_W'(CP_BLOCKS - 1);
  localparam logic [IDX_W-1:0]  MCP_LAST  = IDX_W'(MCP_BLOCKS - 1);
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BPB - 1);

  logic                     valid_q;
  pat_mode_e                mode_q;
  logic [2*UI_PER_BEAT-1:0] data_q;
  logic                     last_q;

  logic                     xfer, begin_run, period_end, restart, adv;
  pat_mode_e                nxt_mode;
  logic [2*UI_PER_BEAT-1:0] nxt_data;
  logic [IDX_W-1:0]         cur_blk, nxt_blk;
  logic [BEAT_W-1:0]        cur_beat, nxt_beat;
  logic [PH_W-1:0]          nxt_jph;
  logic                     nxt_last;

  always_comb begin
    xfer      = valid_q && ready_i;
    begin_run = !valid_q && start_i;
    restart   = begin_run || (xfer && period_end);
    adv       = xfer && !period_end;
    nxt_mode  = restart ? decode_mode(mode_i) : mode_q;
    nxt_last  = (nxt_beat == BEAT_LAST) &&
                (((nxt_mode == PM_CPAT)  && (nxt_blk == CP_LAST)) ||
                 ((nxt_mode == PM_MCPAT) && (nxt_blk == MCP_LAST)));
  end

  pam4_period_ctr #(
    .UPB        (UI_PER_BEAT),
    .BPB        (BPB),
    .CP_BLOCKS  (CP_BLOCKS),
    .MCP_BLOCKS (MCP_BLOCKS),
    .JIT_UI     (JIT_UI),
    .IDX_W      (IDX_W),
    .BEAT_W     (BEAT_W),
    .PH_W       (PH_W)
  ) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .adv        (adv),
    .mode       (mode_q),
    .blk_q      (cur_blk),
    .nxt_blk    (nxt_blk),
    .beat_q     (cur_beat),
    .nxt_beat   (nxt_beat),
    .nxt_jph    (nxt_jph),
    .period_end (period_end)
  );

  pam4_beat_builder #(
    .UPB         (UI_PER_BEAT),
    .JIT_UI      (JIT_UI),
    .JIT_SET_UI  (JIT_SET_UI),
    .JIT_HOLD_UI (JIT_HOLD_UI),
    .PH_W        (PH_W)
  ) u_build (
    .mode (nxt_mode),
    .jph  (nxt_jph),
    .beat (nxt_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      mode_q  <= PM_HI_TOG;
      data_q  <= '0;
      last_q  <= 1'b0;
    end else if (restart || adv) begin
      valid_q <= 1'b1;
      mode_q  <= nxt_mode;
      data_q  <= nxt_data;
      last_q  <= nxt_last;
    end
  end

  assign valid_o    = valid_q;
  assign data_o     = data_q;
  assign blk_idx_o  = cur_blk;
  assign blk_beat_o = cur_beat;
  assign blk_last_o = last_q;

endmodule

// File: rtl/pam4_txpat_gen_chk.sv
module pam4_txpat_gen_chk #(
  parameter int UPB        = 8,
  parameter int BPB        = 16,
  parameter int CP_BLOCKS  = 137,
  parameter int MCP_BLOCKS = 65792,
  parameter int IDX_W      = 17,
  parameter int BEAT_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ready_i,
  input logic              valid_o,
  input logic [2*UPB-1:0]  data_o,
  input logic [IDX_W-1:0]  blk_idx_o,
  input logic [BEAT_W-1:0] blk_beat_o,
  input logic              blk_last_o,
  input logic [2:0]        cur_mode
);

  localparam logic [IDX_W-1:0]  CP_LAST   = IDX_W'(CP_BLOCKS - 1);
  localparam logic [IDX_W-1:0]  MCP_LAST  = IDX_W'(MCP_BLOCKS - 1);
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BPB - 1);

  logic is_blk_mode;
  assign is_blk_mode = (cur_mode == 3'd3) || (cur_mode == 3'd4);

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o); // R1

  AST_HI_TOG_SYMS: assert property (@(posedge clk) disable iff (rst)
    valid_o && cur_mode == 3'd0 |-> data_o[1:0] == 2'b00 && data_o[3:2] == 2'b11); // R2

  AST_BLK_STEP: assert property (@(posedge clk) disable iff (rst)
    valid_o && ready_i && is_blk_mode && blk_beat_o == BEAT_LAST && !blk_last_o
    |=> blk_idx_o == $past(blk_idx_o) + IDX_W'(1) && blk_beat_o == '0); // R5

  AST_CP_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid_o && cur_mode == 3'd3 |-> blk_idx_o <= CP_LAST); // R6

  AST_CP_LAST_POS: assert property (@(posedge clk) disable iff (rst)
    blk_last_o && cur_mode == 3'd3 |-> blk_idx_o == CP_LAST && blk_beat_o == BEAT_LAST); // R6

  AST_MCP_LAST_POS: assert property (@(posedge clk) disable iff (rst)
    blk_last_o && cur_mode == 3'd4 |-> blk_idx_o == MCP_LAST && blk_beat_o == BEAT_LAST); // R7

  AST_MODE_HELD_MID: assert property (@(posedge clk) disable iff (rst)
    valid_o && ready_i && is_blk_mode && !blk_last_o |=> $stable(cur_mode)); // R8

  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (rst)
    valid_o && ready_i && blk_last_o |=> blk_idx_o == '0 && blk_beat_o == '0); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(blk_idx_o) &&
                            $stable(blk_beat_o) && $stable(blk_last_o)); // R9

  AST_NO_BLK_INFO: assert property (@(posedge clk) disable iff (rst)
    valid_o && !is_blk_mode |-> blk_idx_o == '0 && blk_beat_o == '0 && !blk_last_o); // R11

endmodule

bind pam4_txpat_gen pam4_txpat_gen_chk #(
  .UPB        (UI_PER_BEAT),
  .BPB        (BPB),
  .CP_BLOCKS  (CP_BLOCKS),
  .MCP_BLOCKS (MCP_BLOCKS),
  .IDX_W      (IDX_W),
  .BEAT_W     (BEAT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ready_i    (ready_i),
  .valid_o    (valid_o),
  .data_o     (data_o),
  .blk_idx_o  (blk_idx_o),
  .blk_beat_o (blk_beat_o),
  .blk_last_o (blk_last_o),
  .cur_mode   (mode_q)
);

// File: tb/pam4_txpat_gen_tb.sv
`timescale 1ns/1ps
module pam4_txpat_gen_tb;

  localparam int UPB = 8;
  localparam int BPB = 16;
  localparam int CPB = 137;
  localparam int W   = 2 * UPB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    mode_i = 3'd0;
  logic          start_i = 1'b0;
  logic          ready_i = 1'b0;
  logic          valid_o;
  logic [W-1:0]  data_o;
  logic [16:0]   blk_idx_o;
  logic [3:0]    blk_beat_o;
  logic          blk_last_o;

  always #2.5 clk = ~clk;

  pam4_txpat_gen u_dut (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .start_i    (start_i),
    .ready_i    (ready_i),
    .valid_o    (valid_o),
    .data_o     (data_o),
    .blk_idx_o  (blk_idx_o),
    .blk_beat_o (blk_beat_o),
    .blk_last_o (blk_last_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit armed = 0;
  int first_mode = 0;

  logic [W-1:0] q_d[$];
  int           q_idx[$];
  int           q_beat[$];
  bit           q_last[$];
  logic [2:0]   q_drv[$];
  string        q_tag[$];

  // Model of one beat, written from the requirements.
  function automatic logic [W-1:0] exp_beat(int m, int b);
    logic [W-1:0] r = '0;
    for (int k = 0; k < UPB; k++) begin
      logic [1:0] sym;
      int u, g, o, f;
      case (m)
        1: sym = (k % 2 == 1) ? 2'd2 : 2'd1;
        2: begin
          u = (b * UPB + k) % 52;
          g = u / 13;
          o = u % 13;
          f = (g == 0) ? 0 : (g == 1) ? 3 : (g == 2) ? 1 : 2;
          sym = (o < 7) ? 2'(f) : 2'(3 - f);
        end
        3, 4: sym = 2'd0;
        default: sym = (k % 2 == 1) ? 2'd3 : 2'd0;
      endcase
      r[2*k +: 2] = sym;
    end
    return r;
  endfunction

  function automatic int period_beats(int m);
    case (m)
      2: return 13;
      3: return CPB * BPB;
      default: return 1;
    endcase
  endfunction

  function automatic string mtag(int m);
    case (m)
      1: return "R3/R11";
      2: return "R4/R11";
      3: return "R5/R6";
      4: return "R5/R7";
      default: return "R2/R11";
    endcase
  endfunction

  // Code presented on mode_i mid-period; it must be ignored.
  function automatic logic [2:0] junk(int m);
    return (m == 3) ? 3'd1 : 3'd3;
  endfunction

  task automatic push_item(logic [W-1:0] d, int idx, int bt, bit last, logic [2:0] drv, string tag);
    q_d.push_back(d);
    q_idx.push_back(idx);
    q_beat.push_back(bt);
    q_last.push_back(last);
    q_drv.push_back(drv);
    q_tag.push_back(tag);
  endtask

  // Driver: expected beats for whole periods of one mode.
  task automatic push_seg(int m, int nper, int nxt, bit switched);
    int p_len = period_beats(m);
    bit blk = (m == 3) || (m == 4);
    for (int p = 0; p < nper; p++) begin
      for (int b = 0; b < p_len; b++) begin
        bit isend = (b == p_len - 1);
        logic [2:0] drv = isend ? ((p == nper - 1) ? 3'(nxt) : 3'(m)) : junk(m);
        string tag = mtag(m);
        if (switched && p == 0 && b == 0) tag = {tag, " R8"};
        push_item(exp_beat(m, b), blk ? b / BPB : 0, blk ? b % BPB : 0,
                  (m == 3) && isend, drv, tag);
      end
    end
  endtask

  task automatic push_mcp(int n);
    for (int b = 0; b < n; b++)
      push_item(exp_beat(4, b), b / BPB, b % BPB, 1'b0, 3'd0,
                (b == 0) ? "R5/R7 R8" : "R5/R7");
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor: ready pattern, mode drive and scoreboard compare.
  logic [15:0]  lfsr = 16'hACE1;
  bit           prev_stall = 0;
  logic [W-1:0] p_d;
  logic [16:0]  p_i;
  logic [3:0]   p_b;
  logic         p_l;

  always @(negedge clk) begin
    if (armed && !done) begin
      if (prev_stall) begin
        checks++;
        if (!valid_o || data_o !== p_d || blk_idx_o !== p_i || blk_beat_o !== p_b || blk_last_o !== p_l) begin
          errors++;
          $display("FAIL R9 stall hold: data=%h/%h idx=%0d/%0d beat=%0d/%0d", data_o, p_d, blk_idx_o, p_i, blk_beat_o, p_b);
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ready_i = lfsr[0] | lfsr[1];
      if (!valid_o) mode_i = 3'(first_mode);
      else if (q_d.size() > 0) mode_i = q_drv[0];
      prev_stall = valid_o && !ready_i;
      p_d = data_o; p_i = blk_idx_o; p_b = blk_beat_o; p_l = blk_last_o;
      if (valid_o && ready_i && q_d.size() > 0) begin
        checks++;
        if (data_o !== q_d[0] || blk_idx_o !== 17'(q_idx[0]) || blk_beat_o !== 4'(q_beat[0]) || blk_last_o !== q_last[0]) begin
          errors++;
          $display("FAIL %s data=%h/%h idx=%0d/%0d beat=%0d/%0d last=%0b/%0b", q_tag[0],
                   data_o, q_d[0], blk_idx_o, q_idx[0], blk_beat_o, q_beat[0], blk_last_o, q_last[0]);
        end
        void'(q_d.pop_front());
        void'(q_idx.pop_front());
        void'(q_beat.pop_front());
        void'(q_last.pop_front());
        void'(q_drv.pop_front());
        void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: queue=%0d expected=0", q_d.size());
      report();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (valid_o !== 1'b0 || data_o !== '0) begin
        errors++;
        $display("FAIL R1 idle: valid=%0b/0 data=%h/0", valid_o, data_o);
      end
    end
    push_seg(0, 3, 1, 1'b0);
    push_seg(1, 2, 2, 1'b1);
    push_seg(2, 2, 6, 1'b1);
    push_seg(6, 2, 3, 1'b1);
    push_seg(3, 1, 2, 1'b1);
    push_seg(2, 1, 4, 1'b1);
    push_mcp(40);
    first_mode = 0;
    armed = 1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    checks++;
    if (valid_o !== 1'b1) begin
      errors++;
      $display("FAIL R1 start: valid=%0b/1", valid_o);
    end
    // R10: start pulse in mid-stream; the scoreboard must see no disturbance.
    wait (q_d.size() < 1500);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    checks++;
    if (valid_o !== 1'b1 || blk_idx_o == 17'd0) begin
      errors++;
      $display("FAIL R10 restart seen: valid=%0b/1 idx=%0d/nonzero", valid_o, blk_idx_o);
    end
    while (q_d.size() > 0 && !done) @(negedge clk);
    report();
  end

endmodule